// File: doc/BRIEF.md
# Buck On-Time Fault Monitor

This block watches one channel of a constant-off-time buck converter and decides when that channel must stop switching. Once per switching cycle it receives a cycle event with two qualifiers. The first says that the peak-current trip landed inside the short on-time window, which lies after the blank time and before the minimum on-time. The second says that the on-time ran all the way to its maximum. Alongside these it samples four level inputs: a low-output-voltage indication, an overtemperature indication, a startup-phase indication and the operating mode (normal or limp home).

Short-on-time cycles are counted even when good cycles fall between them. The count is discarded only after a run of consecutive good cycles, and it is frozen while startup is indicated. When the count passes its limit, a latched fault is raised. It is classed as a short to ground when the output voltage is low, or as a minimum-on-time fault otherwise, and either class holds the buck off. Two maximum-on-time cycles in a row raise a separate flag and open a short timed off window. In normal mode, latched flags are removed only by a read-and-clear pulse. In limp home they are removed by a periodic restart tick instead.

Top module: `otm_monitor`

## Requirements
- R1: Out of reset all flags, `buck_off`, `tmax_off`, `fe_crit` and `fe_noncrit` are 0.
- R2: Each cycle event with `cyc_short`=1 adds one to a failure count, including when good cycles fall between short cycles. The event that takes the count beyond FAIL_LIMIT (the 33rd at the default of 32) sets `flag_tonmin` and `buck_off` when `vled_low`=0. The count then returns to zero. The FAIL_LIMIT-th short event sets no flag.
- R3: GOOD_RUN consecutive cycle events with `cyc_short`=0 reset the failure count to zero. A run of GOOD_RUN-1 such events leaves the count unchanged.
- R4: Cycle events that arrive while `startup`=1 change neither the failure count nor the good-run count.
- R5: When the validating short event arrives with `vled_low`=1, `flag_short` is set instead of `flag_tonmin`, and `buck_off` is 1.
- R6: Two consecutive cycle events with `cyc_tonmax`=1 set `flag_tonmax`. A single such event followed by one with `cyc_tonmax`=0 sets nothing. From the detecting edge, `tmax_off` and `buck_off` are 1 for TMAXOFF_CYC clocks. In normal mode `buck_off` then returns to 0 while `flag_tonmax` stays set.
- R7: With `limp`=0, a `rc_clear` pulse clears every latched flag whose fault is not present at that edge, and this releases `buck_off`. A `rc_clear` in the same cycle as a new detection leaves that flag set.
- R8: `flag_ovt` is set while `ovt_hot`=1 and forces `buck_off`. It stays set after `ovt_hot` falls, and a clear has no effect while `ovt_hot`=1.
- R9: With `limp`=1, `rc_clear` has no effect. Latched flags are cleared on every RESTART_CYC-th clock edge counted from the edge that first samples `limp`=1.
- R10: With `limp`=1, `flag_tonmax` keeps `buck_off` at 1 after the timed off window ends, until the next restart tick.
- R11: `fe_crit` is the OR of `flag_tonmin`, `flag_short` and `flag_ovt`. `fe_noncrit` equals `flag_tonmax`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | One-clock pulse marking the end of a switching cycle |
| cyc_short | input | 1 | Peak trip fell inside the short on-time window (qualifies cyc_valid) |
| cyc_tonmax | input | 1 | On-time reached its maximum (qualifies cyc_valid) |
| vled_low | input | 1 | Output voltage below the short threshold |
| ovt_hot | input | 1 | Overtemperature present (above hysteresis release point) |
| startup | input | 1 | Startup phase active; failure counting frozen |
| limp | input | 1 | 1 = limp home, 0 = normal mode |
| rc_clear | input | 1 | Read-and-clear pulse for the status flags |
| flag_tonmin | output | 1 | Latched minimum-on-time fault |
| flag_short | output | 1 | Latched output short-to-ground fault |
| flag_tonmax | output | 1 | Latched maximum-on-time fault |
| flag_ovt | output | 1 | Latched overtemperature fault |
| buck_off | output | 1 | Buck must not switch |
| tmax_off | output | 1 | Timed off window after a maximum-on-time detection |
| fe_crit | output | 1 | Summary of faults that disable the channel |
| fe_noncrit | output | 1 | Summary of faults that do not latch the channel off |

## Verification
Short cycles are driven both back-to-back and interleaved with good cycles. This distinguishes a count of non-consecutive events from a consecutive-run detector. Good runs of exactly GOOD_RUN and GOOD_RUN-1 are placed in the middle of a short sequence, so the flag then appears either one event past the limit from the reset point or at the accumulated total. The same count pattern is repeated with startup asserted, with the low-voltage qualifier set, with a colliding clear, and in limp home, so that each variant shows up as a different flag, a different timing or a different release point. Maximum-on-time cycles are given as isolated events and as pairs, and the off window is probed on both sides of its last clock.

// File: rtl/otm_pkg.sv
package otm_pkg;
  typedef struct packed {
    logic tonmin;
    logic short_gnd;
    logic tonmax;
    logic ovt;
  } otm_flags_t;
endpackage

// File: rtl/otm_fail_counter.sv
module otm_fail_counter #(
  parameter int FAIL_LIMIT = 32,
  parameter int GOOD_RUN   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid,
  input  logic cyc_short,
  input  logic startup,
  output logic fail_val
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam int RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [CNT_W-1:0] LIM      = CNT_W'(FAIL_LIMIT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [RUN_W-1:0] run_q, run_n;
  logic             cnt_en;

  assign cnt_en = cyc_valid && !startup;

  always_comb begin
    cnt_n    = cnt_q;
    run_n    = run_q;
    fail_val = 1'b0;
    if (cnt_en) begin
      if (cyc_short) begin
        run_n = '0;
        if (cnt_q == LIM) begin
          fail_val = 1'b1;
          cnt_n    = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else if (run_q == RUN_LAST) begin
        run_n = '0;
        cnt_n = '0;
      end else begin
        run_n = run_q + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  // R4
  startup_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && startup) |=> ($stable(cnt_q) && $stable(run_q)));
endmodule

// File: rtl/otm_tonmax_detect.sv
module otm_tonmax_detect #(
  parameter int TMAXOFF_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid,
  input  logic cyc_tonmax,
  output logic tmax_det,
  output logic tmax_off
);
  localparam int TM_W = $clog2(TMAXOFF_CYC + 1);
  localparam logic [TM_W-1:0] TM_LOAD = TM_W'(TMAXOFF_CYC);

  logic            prev_q, prev_n;
  logic [TM_W-1:0] tmr_q, tmr_n;

  assign tmax_det = cyc_valid && cyc_tonmax && prev_q;

  always_comb begin
    prev_n = prev_q;
    if (cyc_valid) prev_n = cyc_tonmax && !tmax_det;
    if (tmax_det)          tmr_n = TM_LOAD;
    else if (tmr_q != '0)  tmr_n = tmr_q - TM_W'(1);
    else                   tmr_n = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      prev_q <= prev_n;
      tmr_q  <= tmr_n;
    end
  end

  assign tmax_off = (tmr_q != '0);

  // R6
  tmax_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmax_det |=> tmax_off);
endmodule

// File: rtl/otm_restart_timer.sv
module otm_restart_timer #(
  parameter int RESTART_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic limp,
  output logic tick
);
  localparam int RS_W = (RESTART_CYC > 1) ? $clog2(RESTART_CYC) : 1;
  localparam logic [RS_W-1:0] RS_LAST = RS_W'(RESTART_CYC - 1);

  logic [RS_W-1:0] cnt_q, cnt_n;

  assign tick = limp && (cnt_q == RS_LAST);

  always_comb begin
    if (!limp || tick) cnt_n = '0;
    else               cnt_n = cnt_q + RS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R9
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !limp |=> (cnt_q == '0));
endmodule

// File: rtl/otm_monitor.sv
module otm_monitor
  import otm_pkg::*;
#(
  parameter int FAIL_LIMIT  = 32,
  parameter int GOOD_RUN    = 8,
  parameter int TMAXOFF_CYC = 16,
  parameter int RESTART_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid,
  input  logic cyc_short,
  input  logic cyc_tonmax,
  input  logic vled_low,
  input  logic ovt_hot,
  input  logic startup,
  input  logic limp,
  input  logic rc_clear,
  output logic flag_tonmin,
  output logic flag_short,
  output logic flag_tonmax,
  output logic flag_ovt,
  output logic buck_off,
  output logic tmax_off,
  output logic fe_crit,
  output logic fe_noncrit
);
  otm_flags_t flg_q, flg_n;
  logic       fail_val, tmax_det, restart_tick, clr;

  otm_fail_counter #(.FAIL_LIMIT(FAIL_LIMIT), .GOOD_RUN(GOOD_RUN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_short(cyc_short),
    .startup(startup), .fail_val(fail_val));

  otm_tonmax_detect #(.TMAXOFF_CYC(TMAXOFF_CYC)) u_tmax (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_tonmax(cyc_tonmax),
    .tmax_det(tmax_det), .tmax_off(tmax_off));

  otm_restart_timer #(.RESTART_CYC(RESTART_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .limp(limp), .tick(restart_tick));

  // Clear source: software in normal mode, periodic tick in limp home.
  assign clr = limp ? restart_tick : rc_clear;

  always_comb begin
    flg_n.tonmin    = (fail_val && !vled_low) || (flg_q.tonmin    && !clr);
    flg_n.short_gnd = (fail_val &&  vled_low) || (flg_q.short_gnd && !clr);
    flg_n.tonmax    = tmax_det                || (flg_q.tonmax    && !clr);
    flg_n.ovt       = ovt_hot                 || (flg_q.ovt       && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_n;
  end

  assign flag_tonmin = flg_q.tonmin;
  assign flag_short  = flg_q.short_gnd;
  assign flag_tonmax = flg_q.tonmax;
  assign flag_ovt    = flg_q.ovt;
  assign fe_crit     = flg_q.tonmin || flg_q.short_gnd || flg_q.ovt;
  assign fe_noncrit  = flg_q.tonmax;
  assign buck_off    = fe_crit || tmax_off || (limp && flg_q.tonmax);

  // R7
  rc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!limp && rc_clear && !fail_val) |=> !flag_tonmin);

  // R6
  tmax_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_tonmax) |-> tmax_off);

  // R9
  limp_rc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limp && !restart_tick && flag_tonmin) |=> flag_tonmin);
endmodule

// File: tb/otm_monitor_tb.sv
module otm_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FAIL_LIMIT = 32;
  localparam int GOOD_RUN   = 8;
  localparam int TMAXOFF    = 16;
  localparam int RESTART    = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc_valid, cyc_short, cyc_tonmax, vled_low, ovt_hot, startup, limp, rc_clear;
  logic flag_tonmin, flag_short, flag_tonmax, flag_ovt, buck_off, tmax_off, fe_crit, fe_noncrit;

  always #(CLK_PERIOD/2) clk = ~clk;

  otm_monitor #(.FAIL_LIMIT(FAIL_LIMIT), .GOOD_RUN(GOOD_RUN),
                .TMAXOFF_CYC(TMAXOFF), .RESTART_CYC(RESTART)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_short(cyc_short),
    .cyc_tonmax(cyc_tonmax), .vled_low(vled_low), .ovt_hot(ovt_hot),
    .startup(startup), .limp(limp), .rc_clear(rc_clear),
    .flag_tonmin(flag_tonmin), .flag_short(flag_short), .flag_tonmax(flag_tonmax),
    .flag_ovt(flag_ovt), .buck_off(buck_off), .tmax_off(tmax_off),
    .fe_crit(fe_crit), .fe_noncrit(fe_noncrit));

  // Output vector: {tonmin, short, tonmax, ovt, buck_off, tmax_off, fe_crit, fe_noncrit}
  typedef struct {
    string      req;
    logic [7:0] exp;
    logic [7:0] mask;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  task automatic expect_out(input string req, input logic [7:0] e, input logic [7:0] m);
    item_t it;
    it.req = req; it.exp = e; it.mask = m;
    q.push_back(it);
    -> chk_ev;
  endtask

  // Monitor: pops expected items and compares against the live outputs.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = {flag_tonmin, flag_short, flag_tonmax, flag_ovt,
               buck_off, tmax_off, fe_crit, fe_noncrit};
        n_run++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b (mask %b)", it.req, act, it.exp, it.mask);
        end
      end
    end
  end

  task automatic run_cyc(input logic s, input logic t);
    cyc_valid = 1'b1; cyc_short = s; cyc_tonmax = t;
    @(negedge clk);
    cyc_valid = 1'b0; cyc_short = 1'b0; cyc_tonmax = 1'b0;
  endtask

  task automatic shorts(input int n);
    for (int i = 0; i < n; i++) run_cyc(1'b1, 1'b0);
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) run_cyc(1'b0, 1'b0);
  endtask

  task automatic rc_pulse();
    rc_clear = 1'b1;
    @(negedge clk);
    rc_clear = 1'b0;
  endtask

  localparam logic [7:0] ALL   = 8'hFF;
  localparam logic [7:0] NONE  = 8'h00;
  localparam logic [7:0] TMIN  = 8'b1000_1010;
  localparam logic [7:0] SHT   = 8'b0100_1010;
  localparam logic [7:0] TMAXW = 8'b0010_1101;
  localparam logic [7:0] TMAXL = 8'b0010_0001;
  localparam logic [7:0] OVT   = 8'b0001_1010;

  initial begin
    rst_n = 1'b0; cyc_valid = 0; cyc_short = 0; cyc_tonmax = 0;
    vled_low = 0; ovt_hot = 0; startup = 0; limp = 0; rc_clear = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset state", NONE, ALL);

    // R2: non-consecutive shorts, each followed by a short good run
    for (int i = 0; i < FAIL_LIMIT; i++) begin
      run_cyc(1'b1, 1'b0);
      goods(3);
    end
    expect_out("R2 limit reached, no flag yet", NONE, ALL);
    run_cyc(1'b1, 1'b0);
    expect_out("R2 count beyond limit sets tonmin", TMIN, ALL);
    expect_out("R11 critical summary", 8'b0000_0010, 8'b0000_0011);
    rc_pulse();
    expect_out("R7 read-and-clear releases buck", NONE, ALL);

    // R3: GOOD_RUN-1 good cycles keep the count
    shorts(20); goods(GOOD_RUN - 1); shorts(12);
    expect_out("R3 short run keeps count (no flag at 32)", NONE, ALL);
    run_cyc(1'b1, 1'b0);
    expect_out("R3 accumulated count validates", TMIN, ALL);
    rc_pulse();
    // R3: GOOD_RUN good cycles reset the count
    shorts(20); goods(GOOD_RUN); shorts(FAIL_LIMIT);
    expect_out("R3 full good run resets count", NONE, ALL);
    run_cyc(1'b1, 1'b0);
    expect_out("R3 flag after fresh count", TMIN, ALL);
    rc_pulse();

    // R4: startup freezes counting
    startup = 1'b1;
    shorts(40);
    startup = 1'b0;
    shorts(FAIL_LIMIT);
    expect_out("R4 startup cycles not counted", NONE, ALL);
    run_cyc(1'b1, 1'b0);
    expect_out("R4 flag after startup ends", TMIN, ALL);
    rc_pulse();

    // R5: low output voltage classifies as short
    shorts(FAIL_LIMIT);
    vled_low = 1'b1;
    run_cyc(1'b1, 1'b0);
    vled_low = 1'b0;
    expect_out("R5 short flag with low output", SHT, ALL);
    rc_pulse();
    expect_out("R7 short flag cleared", NONE, ALL);

    // R7: clear in same cycle as detection keeps the flag
    shorts(FAIL_LIMIT);
    rc_clear = 1'b1;
    run_cyc(1'b1, 1'b0);
    rc_clear = 1'b0;
    expect_out("R7 collision keeps flag", TMIN, ALL);
    rc_pulse();

    // R6: isolated max on-time events do not detect
    run_cyc(1'b0, 1'b1); run_cyc(1'b0, 1'b0); run_cyc(1'b0, 1'b1); run_cyc(1'b0, 1'b0);
    expect_out("R6 isolated max on-time ignored", NONE, ALL);
    run_cyc(1'b0, 1'b1); run_cyc(1'b0, 1'b1);
    expect_out("R6 consecutive max on-time detects", TMAXW, ALL);
    expect_out("R11 non-critical summary", 8'b0000_0001, 8'b0000_0011);
    repeat (TMAXOFF - 1) @(negedge clk);
    expect_out("R6 off window last clock", TMAXW, ALL);
    @(negedge clk);
    expect_out("R6 buck resumes, flag held", TMAXL, ALL);
    rc_pulse();
    expect_out("R7 max flag cleared", NONE, ALL);

    // R8: overtemperature
    ovt_hot = 1'b1;
    @(negedge clk);
    expect_out("R8 overtemperature latched", OVT, ALL);
    rc_pulse();
    expect_out("R8 clear ignored while hot", OVT, ALL);
    ovt_hot = 1'b0;
    @(negedge clk);
    expect_out("R8 flag held after cooling", OVT, ALL);
    rc_pulse();
    expect_out("R8 clear after cooling", NONE, ALL);

    // R9/R10: limp home (edge 1 is the first edge sampling limp=1)
    limp = 1'b1;
    shorts(FAIL_LIMIT + 1);                 // edges 1..33
    expect_out("R9 fault in limp home", TMIN, ALL);
    rc_pulse();                              // edge 34
    expect_out("R9 read-and-clear ignored in limp", TMIN, ALL);
    repeat (29) @(negedge clk);              // edge 63
    expect_out("R9 held before restart tick", TMIN, ALL);
    @(negedge clk);                          // edge 64
    expect_out("R9 auto-restart clears", NONE, ALL);
    run_cyc(1'b0, 1'b1); run_cyc(1'b0, 1'b1); // edges 65,66
    expect_out("R10 max on-time in limp", TMAXW, ALL);
    repeat (24) @(negedge clk);              // edge 90
    expect_out("R10 buck held off after window", 8'b0010_1001, ALL);
    repeat (37) @(negedge clk);              // edge 127
    expect_out("R10 held until tick", 8'b0010_1001, ALL);
    @(negedge clk);                          // edge 128
    expect_out("R9 second restart tick clears", NONE, ALL);
    limp = 1'b0;
    @(negedge clk);

    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule